// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit turns one block-transfer instruction into a series of single-word beats. It takes a start strobe, the 32-bit instruction word and the current value of the base register. From these it works out the first address, the last address and the updated base value. It then walks the 16-bit register list from the lowest set bit to the highest. On each cycle it presents one register index and one word address. The memory port and the register file that use these beats are outside the block.

The four stepping modes are chosen by two instruction bits. They are: after or before, which picks whether the address steps past the base first, and up or down. All four modes move through memory in rising address order, so the lowest register always maps to the lowest address. When the final beat has gone out, the block raises a one-cycle completion pulse. This pulse carries the new base value, a flag saying whether that value should be written back, and an error flag. The error flag is set if the address walk did not end on the computed final address.

For a load, a beat that targets register 15 is flagged as a program-counter update. The data word returned for that beat is presented with bit 0 cleared.

Top module: `lsm_seq`

## Requirements
- R1: After reset, busy, beat_valid, done, wb_en and abort are all 0.
- R2: Increment-after mode (bit 24 = 0, bit 23 = 1): the first beat address is the base, and the new base is base + 4·n. Here n is the number of set bits in bits 15:0.
- R3: Increment-before mode (bit 24 = 1, bit 23 = 1): the first beat address is base + 4, and the new base is base + 4·n.
- R4: Decrement-after mode (bit 24 = 0, bit 23 = 0): the first beat address is base − 4·n + 4, and the new base is base − 4·n.
- R5: Decrement-before mode (bit 24 = 1, bit 23 = 0): the first beat address is base − 4·n, and the new base is base − 4·n.
- R6: A start accepted while idle produces n beats on n consecutive cycles, beginning the cycle after the start. Register indices rise through the set bits of the list. Each beat's address is 4 above the previous one, and beat_last is high on the final beat only.
- R7: done pulses for exactly one cycle, on the cycle after the final beat. With it, wb_en equals bit 21 and wb_reg equals bits 19:16.
- R8: An empty list gives done on the cycle after the start, with no beats and wb_value equal to the base.
- R9: beat_to_pc is high only on a beat for register 15 of a load (bit 20 = 1). pc_value is beat_rdata with bit 0 forced to 0.
- R10: abort, which is valid with done, is set when the address after the last beat does not match the computed final address. For every well-formed sequence it is 0.
- R11: start is ignored while busy. The sequence in progress runs unchanged, and the block is idle on the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a transfer (taken only while idle) |
| instr | input | 32 | Block-transfer instruction word |
| base_val | input | AW | Current value of the base register |
| beat_rdata | input | AW | Load data returned for the current beat |
| busy | output | 1 | Sequence in progress |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_reg | output | 4 | Register index of the beat |
| beat_addr | output | AW | Word address of the beat |
| beat_last | output | 1 | Final beat of the sequence |
| beat_to_pc | output | 1 | Beat loads the program counter |
| pc_value | output | AW | beat_rdata with bit 0 cleared |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | Base writeback requested (with done) |
| wb_reg | output | 4 | Base register index |
| wb_value | output | AW | New base value |
| abort | output | 1 | End-address mismatch (with done) |

## Verification
Each of the four modes is swept with the same list set: empty, full, all sixteen single-bit lists, and a spread of pseudo-random lists. Two base values are used, one of them placed so that the address arithmetic wraps. The single-bit and full lists tell apart off-by-one errors between the after and before modes, and errors in the priority-pick order. The random lists expose popcount mistakes. Write-back and load flags alternate across runs, which separates wb_en gating from the register-15 handling. A second start is injected in mid-sequence to show that it is ignored.

// File: rtl/lsm_pkg.sv
// Package: shared field positions, stepping modes and sequencer states.
// Assumes a 32-bit instruction word and a 16-entry register list.
package lsm_pkg;
    localparam int LSM_NREG    = 16;
    localparam int LSM_BASE_LO = 16;
    localparam int LSM_BIT_L   = 20;
    localparam int LSM_BIT_W   = 21;
    localparam int LSM_BIT_U   = 23;
    localparam int LSM_BIT_P   = 24;

    // Encoding is {before, up}.
    typedef enum logic [1:0] {
        WALK_DA = 2'b00,
        WALK_IA = 2'b01,
        WALK_DB = 2'b10,
        WALK_IB = 2'b11
    } walk_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FIN  = 2'b10
    } seq_state_e;
endpackage

// File: rtl/lsm_popcount.sv
// Counts the set bits of a vector.
// Assumes CW is wide enough to hold N.
module lsm_popcount #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits,
    output logic [CW-1:0] count
);
    // Purpose: sum the bits as a plain add chain.
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CW'(bits[i]);
        end
    end
endmodule

// File: rtl/lsm_span_calc.sv
// Derives the first beat address, the final beat address and the new base
// from the mode, the base value and the beat count.
// Assumes word beats of 4 bytes and wraps modulo 2^AW.
module lsm_span_calc
    import lsm_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 5
) (
    input  walk_e         walk,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    output logic [AW-1:0] first_addr,
    output logic [AW-1:0] final_addr,
    output logic [AW-1:0] new_base
);
    localparam logic [AW-1:0] WORD = AW'(4);

    logic [AW-1:0] span;
    assign span = AW'(count) << 2;

    // Purpose: select the address window for the chosen mode.
    always_comb begin
        unique case (walk)
            WALK_IA: begin
                first_addr = base;
                final_addr = base + span - WORD;
                new_base   = base + span;
            end
            WALK_IB: begin
                first_addr = base + WORD;
                final_addr = base + span;
                new_base   = base + span;
            end
            WALK_DA: begin
                first_addr = base - span + WORD;
                final_addr = base;
                new_base   = base - span;
            end
            default: begin
                first_addr = base - span;
                final_addr = base - WORD;
                new_base   = base - span;
            end
        endcase
    end
endmodule

// File: rtl/lsm_prio_pick.sv
// Lowest-index-first priority picker. Returns a one-hot grant and its index.
// Assumes N is a power of two.
module lsm_prio_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [N:0] below;
    assign below[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            assign grant[g]   = req[g] & ~below[g];
            assign below[g+1] = below[g] | req[g];
        end
    endgenerate

    assign any = below[N];

    // Purpose: encode the one-hot grant into a binary index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/lsm_seq.sv
// Block-transfer sequencer top. Latches the transfer window when started,
// then issues one beat per cycle over the pending list bits in rising order.
// A done cycle with writeback and error status follows the last beat.
// Assumes the instruction is stable only in the start cycle.
module lsm_seq
    import lsm_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [31:0]   instr,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] beat_rdata,
    output logic          busy,
    output logic          beat_valid,
    output logic [3:0]    beat_reg,
    output logic [AW-1:0] beat_addr,
    output logic          beat_last,
    output logic          beat_to_pc,
    output logic [AW-1:0] pc_value,
    output logic          done,
    output logic          wb_en,
    output logic [3:0]    wb_reg,
    output logic [AW-1:0] wb_value,
    output logic          abort
);
    localparam int NREG = LSM_NREG;
    localparam int IW   = $clog2(NREG);
    localparam int CW   = $clog2(NREG + 1);
    localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);
    localparam logic [AW-1:0] WORD   = AW'(4);

    logic [NREG-1:0] list_in;
    walk_e           walk_in;
    logic [CW-1:0]   cnt_in;
    logic [AW-1:0]   first_in, final_in, wb_in;
    logic            unused_bits;

    assign list_in     = instr[NREG-1:0];
    assign walk_in     = walk_e'({instr[LSM_BIT_P], instr[LSM_BIT_U]});
    assign unused_bits = ^{instr[31:25], instr[22]};

    lsm_popcount #(.N(NREG), .CW(CW)) u_cnt (
        .bits  (list_in),
        .count (cnt_in)
    );

    lsm_span_calc #(.AW(AW), .CW(CW)) u_span (
        .walk       (walk_in),
        .base       (base_val),
        .count      (cnt_in),
        .first_addr (first_in),
        .final_addr (final_in),
        .new_base   (wb_in)
    );

    seq_state_e      state_q;
    logic [NREG-1:0] pend_q;
    logic [AW-1:0]   addr_q, final_q, wbv_q;
    logic            wbw_q, load_q, abort_q;
    logic [3:0]      base_idx_q;

    logic [NREG-1:0] grant;
    logic [IW-1:0]   pick_idx;
    logic            pick_any;
    logic            is_last;

    lsm_prio_pick #(.N(NREG), .IW(IW)) u_pick (
        .req   (pend_q),
        .grant (grant),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    assign is_last = pick_any && ((pend_q & ~grant) == '0);

    // Purpose: the sequencer state, the pending list and the latched window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pend_q     <= '0;
            addr_q     <= '0;
            final_q    <= '0;
            wbv_q      <= '0;
            wbw_q      <= 1'b0;
            load_q     <= 1'b0;
            abort_q    <= 1'b0;
            base_idx_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    pend_q     <= list_in;
                    addr_q     <= first_in;
                    final_q    <= final_in;
                    wbv_q      <= wb_in;
                    wbw_q      <= instr[LSM_BIT_W];
                    load_q     <= instr[LSM_BIT_L];
                    base_idx_q <= instr[LSM_BASE_LO +: 4];
                    abort_q    <= 1'b0;
                    state_q    <= (list_in == '0) ? ST_FIN : ST_RUN;
                end
                ST_RUN: begin
                    pend_q <= pend_q & ~grant;
                    addr_q <= addr_q + WORD;
                    if (is_last) begin
                        state_q <= ST_FIN;
                        abort_q <= (addr_q != final_q);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: drive the beat and completion outputs from the state.
    always_comb begin
        busy       = (state_q != ST_IDLE);
        beat_valid = (state_q == ST_RUN);
        beat_reg   = 4'(pick_idx);
        beat_addr  = addr_q;
        beat_last  = beat_valid && is_last;
        beat_to_pc = beat_valid && load_q && (pick_idx == PC_IDX);
        pc_value   = {beat_rdata[AW-1:1], 1'b0};
        done       = (state_q == ST_FIN);
        wb_en      = done && wbw_q;
        wb_reg     = base_idx_q;
        wb_value   = wbv_q;
        abort      = done && abort_q;
    end
endmodule

// File: rtl/lsm_seq_chk.sv
// Checker for lsm_seq: protocol properties on the top-level ports.
// Assumes synchronous active-low reset.
module lsm_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          beat_valid,
    input logic [3:0]    beat_reg,
    input logic [AW-1:0] beat_addr,
    input logic          beat_last,
    input logic          beat_to_pc,
    input logic          done,
    input logic          wb_en,
    input logic          abort
);
    assert_beat_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_last |=> beat_valid && beat_addr == $past(beat_addr) + AW'(4));

    assert_reg_rising_R6: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_last |=> beat_reg > $past(beat_reg));

    assert_done_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_last |=> done && !beat_valid);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    assert_wb_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    assert_pc_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_to_pc |-> beat_valid && beat_reg == 4'hF);

    assert_no_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !abort);

    assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && beat_valid && !beat_last |=> beat_valid);
endmodule

bind lsm_seq lsm_seq_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .beat_valid (beat_valid),
    .beat_reg   (beat_reg),
    .beat_addr  (beat_addr),
    .beat_last  (beat_last),
    .beat_to_pc (beat_to_pc),
    .done       (done),
    .wb_en      (wb_en),
    .abort      (abort)
);

// File: tb/tb_lsm_seq.sv
// Bench: sweeps every mode over a fixed set of register lists and bases,
// with all expected values computed arithmetically.
module tb_lsm_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base_val = '0;
    logic [31:0] beat_rdata = '0;
    logic        busy, beat_valid, beat_last, beat_to_pc, done, wb_en, abort;
    logic [3:0]  beat_reg, wb_reg;
    logic [31:0] beat_addr, pc_value, wb_value;

    int compared = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    lsm_seq #(.AW(32)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .base_val(base_val), .beat_rdata(beat_rdata), .busy(busy),
        .beat_valid(beat_valid), .beat_reg(beat_reg), .beat_addr(beat_addr),
        .beat_last(beat_last), .beat_to_pc(beat_to_pc), .pc_value(pc_value),
        .done(done), .wb_en(wb_en), .wb_reg(wb_reg), .wb_value(wb_value),
        .abort(abort)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b01:   return "R2";
            2'b11:   return "R3";
            2'b00:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic run_one(input logic [1:0] mode, input logic w, input logic ld,
                           input logic [15:0] list, input logic [31:0] base);
        int n = $countones(list);
        logic [31:0] span = 32'(n) * 4;
        logic [31:0] exp_first, exp_wb, cur;
        logic [31:0] word;
        int k = 0;
        case (mode)
            2'b01:   begin exp_first = base;            exp_wb = base + span; end
            2'b11:   begin exp_first = base + 4;        exp_wb = base + span; end
            2'b00:   begin exp_first = base - span + 4; exp_wb = base - span; end
            default: begin exp_first = base - span;     exp_wb = base - span; end
        endcase
        word = '0;
        word[15:0]  = list;
        word[19:16] = list[3:0] ^ 4'h5;
        word[20]    = ld;
        word[21]    = w;
        word[24:23] = mode;
        @(negedge clk);
        instr = word; base_val = base; start = 1'b1;
        @(negedge clk);
        start = 1'b0; instr = ~word; base_val = ~base;
        cur = exp_first;
        for (int r = 0; r < 16; r++) begin
            if (list[r]) begin
                beat_rdata = {16'hC3C3, 8'(k), 4'(r), 4'hF};
                #1;
                check("R6 beat_valid", 32'(beat_valid), 32'd1);
                check("R6 beat_reg", 32'(beat_reg), 32'(r));
                check({mode_tag(mode), " beat_addr"}, beat_addr, cur);
                check("R6 beat_last", 32'(beat_last), 32'(k == n - 1));
                check("R9 beat_to_pc", 32'(beat_to_pc), 32'(ld && r == 15));
                if (ld && r == 15)
                    check("R9 pc_value", pc_value, {16'hC3C3, 8'(k), 4'(r), 4'hE});
                if (k == 0 && n >= 2) begin
                    start = 1'b1; instr = 32'h01A0_0001; // R11 intrusion
                end
                @(negedge clk);
                start = 1'b0;
                cur = cur + 4;
                k++;
            end
        end
        #1;
        if (n == 0) check("R8 empty done", 32'(done), 32'd1);
        else        check("R7 done", 32'(done), 32'd1);
        check("R6 no beat at done", 32'(beat_valid), 32'd0);
        check("R7 wb_en", 32'(wb_en), 32'(w));
        check("R7 wb_reg", 32'(wb_reg), 32'(list[3:0] ^ 4'h5));
        if (n == 0) check("R8 wb_value", wb_value, base);
        else        check({mode_tag(mode), " wb_value"}, wb_value, exp_wb);
        check("R10 abort", 32'(abort), 32'd0);
        @(negedge clk);
        #1;
        check("R11 idle after done", 32'(busy), 32'd0);
        check("R7 done one cycle", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [15:0] lists [30];
        logic [31:0] seed = 32'h1234_5678;
        lists[0] = 16'h0000;
        lists[1] = 16'hFFFF;
        for (int i = 0; i < 16; i++) lists[2 + i] = 16'(1) << i;
        for (int i = 18; i < 30; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            lists[i] = seed[31:16];
        end
        repeat (3) @(negedge clk);
        #1;
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 beat_valid", 32'(beat_valid), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 wb_en", 32'(wb_en), 32'd0);
        check("R1 abort", 32'(abort), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 2; b++) begin
                for (int i = 0; i < 30; i++) begin
                    run_one(2'(m), 1'((i + b) % 2), 1'((i / 2 + m) % 2), lists[i],
                            (b == 0) ? 32'h0000_0010 : 32'hFFFF_FFF8);
                end
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule